// File: doc/BRIEF.md
# Pixel Shift Queue with Object Overlay

This block is a small circular queue of pixels that sits between the tile fetcher and the pixel output stage of a tile-based display pipeline. The fetcher hands over one tile row at a time as a pair of bitplane bytes, a low plane and a high plane, together with a palette number, a background-priority flag and a mirror flag. The block expands that row into eight 2-bit colour entries and appends them at its write position. Each entry keeps the row's palette and priority, plus a marker that says whether an object has claimed the slot.

A second operation lays an object row over the eight entries that start at the current read position. An object pixel with colour zero is transparent. An object pixel also never replaces an entry that an earlier object has already claimed. The output stage pulls one pixel per request. When the queue is empty, a request returns an all-zero pixel and raises an underflow flag. Palette lookup, fetch timing and the final mixing rules are handled by other blocks.

Top module: `pixel_shift_fifo`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) empties the queue. After it, level reads 0 and pix_valid and pix_underflow read 0.
- R2: A row push is accepted (push_accept high, combinational) only when at least 8 slots are free and obj_valid is low. An accepted push raises level by 8 at the next edge. level never exceeds DEPTH.
- R3: The colour of each pixel is a 2-bit value. Bit 0 comes from the low plane and bit 1 comes from the high plane at the same bit position.
- R4: When the mirror flag is 0, the eight pixels of a row are queued from plane bit 7 down to bit 0. When the flag is 1, they are queued from bit 0 up to bit 7.
- R5: Every pushed entry keeps its row's palette number and priority flag. Its object marker (pix_obj) reads 0.
- R6: Pops return entries in the order they were queued. This holds across wrap of the read and write positions. A push and a pop may be accepted in the same cycle.
- R7: An overlay applies object pixel j to the slot j places after the read position, modulo DEPTH, for j = 0..7. Pixel j is taken from the plane bits in the same order as R4.
- R8: An overlay writes a slot only when the object pixel's colour is non-zero and the slot's object marker is 0. A written slot takes the object's colour, palette and priority, and its object marker becomes 1.
- R9: In a cycle with obj_valid high, any push request and any pop request are ignored.
- R10: A pop request while level is 0 gives, one cycle later, pix_underflow=1, pix_valid=0 and all pixel fields zero. level stays unchanged.
- R11: An accepted pop gives its entry on the pix_* outputs one cycle later with pix_valid=1, and level falls by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Request to append one tile row |
| push_lo | input | 8 | Low bitplane of the row |
| push_hi | input | 8 | High bitplane of the row |
| push_pal | input | 3 | Palette number of the row |
| push_prio | input | 1 | Background-priority flag of the row |
| push_flip | input | 1 | Mirror bit order of the row |
| push_accept | output | 1 | Row is taken this cycle |
| obj_valid | input | 1 | Request to overlay one object row |
| obj_lo | input | 8 | Low bitplane of the object row |
| obj_hi | input | 8 | High bitplane of the object row |
| obj_pal | input | 3 | Palette number of the object |
| obj_prio | input | 1 | Priority flag of the object |
| obj_flip | input | 1 | Mirror bit order of the object |
| pop_valid | input | 1 | Request for one pixel |
| pix_valid | output | 1 | A pixel is presented this cycle |
| pix_color | output | 2 | Colour index of the presented pixel |
| pix_pal | output | 3 | Palette of the presented pixel |
| pix_prio | output | 1 | Priority flag of the presented pixel |
| pix_obj | output | 1 | Presented pixel came from an object |
| pix_underflow | output | 1 | Last request found the queue empty |
| level | output | 5 | Number of queued entries |

## Verification
A corrupt read or write position shows up at the next pop as a pixel out of order. An off-by-one in the slot addressing shows up within eight pops as shifted or mirrored colours. A wrong occupancy count is visible at once on level. It is also visible through push_accept, which is wrongly high or low in the same cycle, and it then shows in the following cycle as a bad underflow flag. An error in the overlay rule stays hidden until the affected slots are popped, and that happens at most DEPTH pops later. The bench therefore drains the queue after each directed overlay and compares every popped field with a model queue kept in the bench.

// File: rtl/pfifo_pkg.sv
// Package pfifo_pkg
// Shared widths and the stored pixel entry for the pixel shift queue.
// Assumes rows are always eight pixels wide.
package pfifo_pkg;
    localparam int PAL_W   = 3;
    localparam int ROW_PIX = 8;

    typedef struct packed {
        logic             obj;
        logic             prio;
        logic [PAL_W-1:0] pal;
        logic [1:0]       color;
    } pix_entry_t;
endpackage

// File: rtl/pfifo_row_expand.sv
// Module pfifo_row_expand
// Splits a bitplane pair into per-slot 2-bit colours. Slot j takes plane
// bit (N-1-j) when mirror is low and plane bit j when mirror is high.
// Purely combinational; shared by the push path and the overlay path.
module pfifo_row_expand #(
    parameter int N = 8
) (
    input  logic [N-1:0]       plane_lo,
    input  logic [N-1:0]       plane_hi,
    input  logic               mirror,
    output logic [N-1:0][1:0]  slot_color
);
    for (genvar j = 0; j < N; j++) begin : g_slot
        // pick the plane bit for slot j according to bit order
        assign slot_color[j] = mirror ? {plane_hi[j], plane_lo[j]}
                                      : {plane_hi[N-1-j], plane_lo[N-1-j]};
    end
endmodule

// File: rtl/pfifo_ptrs.sv
// Module pfifo_ptrs
// Read/write positions and occupancy of the pixel queue. A push moves the
// write position by a full row; a pop moves the read position by one.
// Assumes DEPTH is a power of two and at least ROW; callers only assert
// push_go when can_push is high and pop_go when not_empty is high.
module pfifo_ptrs #(
    parameter int DEPTH = 16,
    parameter int ROW   = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_go,
    input  logic          pop_go,
    output logic [AW-1:0] rd_ptr,
    output logic [AW-1:0] wr_ptr,
    output logic [LW-1:0] level,
    output logic          can_push,
    output logic          not_empty
);
    // free-space and empty decode from the occupancy
    assign can_push  = (level <= LW'(DEPTH - ROW));
    assign not_empty = (level != '0);

    // position and occupancy update; positions wrap by natural width
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_go) wr_ptr <= wr_ptr + AW'(ROW);
            if (pop_go)  rd_ptr <= rd_ptr + AW'(1);
            level <= level + (push_go ? LW'(ROW) : LW'(0)) - (pop_go ? LW'(1) : LW'(0));
        end
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    a_r2_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        push_go |=> level == $past(level) + LW'(ROW) - ($past(pop_go) ? LW'(1) : LW'(0)));

    a_r6_ptr_gap: assert property (@(posedge clk) disable iff (!rst_n)
        AW'(wr_ptr - rd_ptr) == AW'(level));
endmodule

// File: rtl/pixel_shift_fifo.sv
// Module pixel_shift_fifo
// Circular pixel queue. Row pushes append eight expanded entries. Object
// overlays merge into the eight slots from the read position. Pops present
// one entry per request, registered. An overlay cycle blocks push and pop.
// Assumes DEPTH is a power of two, DEPTH >= 8.
module pixel_shift_fifo
    import pfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [7:0]       push_lo,
    input  logic [7:0]       push_hi,
    input  logic [PAL_W-1:0] push_pal,
    input  logic             push_prio,
    input  logic             push_flip,
    output logic             push_accept,
    input  logic             obj_valid,
    input  logic [7:0]       obj_lo,
    input  logic [7:0]       obj_hi,
    input  logic [PAL_W-1:0] obj_pal,
    input  logic             obj_prio,
    input  logic             obj_flip,
    input  logic             pop_valid,
    output logic             pix_valid,
    output logic [1:0]       pix_color,
    output logic [PAL_W-1:0] pix_pal,
    output logic             pix_prio,
    output logic             pix_obj,
    output logic             pix_underflow,
    output logic [LW-1:0]    level
);
    logic [AW-1:0]               rd_ptr;
    logic [AW-1:0]               wr_ptr;
    logic                        can_push;
    logic                        not_empty;
    logic                        pop_req;
    logic                        pop_go;
    logic [ROW_PIX-1:0][1:0]     bg_color;
    logic [ROW_PIX-1:0][1:0]     ob_color;
    logic [AW-1:0]               push_idx [ROW_PIX];
    logic [AW-1:0]               obj_idx  [ROW_PIX];
    logic [ROW_PIX-1:0]          lane_hit;
    pix_entry_t                  mem [DEPTH];
    pix_entry_t                  out_q;

    // overlay owns the cycle; push and pop wait
    assign push_accept = push_valid && !obj_valid && can_push;
    assign pop_req     = pop_valid && !obj_valid;
    assign pop_go      = pop_req && not_empty;

    pfifo_ptrs #(.DEPTH(DEPTH), .ROW(ROW_PIX)) u_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_go   (push_accept),
        .pop_go    (pop_go),
        .rd_ptr    (rd_ptr),
        .wr_ptr    (wr_ptr),
        .level     (level),
        .can_push  (can_push),
        .not_empty (not_empty)
    );

    pfifo_row_expand #(.N(ROW_PIX)) u_bg_expand (
        .plane_lo   (push_lo),
        .plane_hi   (push_hi),
        .mirror     (push_flip),
        .slot_color (bg_color)
    );

    pfifo_row_expand #(.N(ROW_PIX)) u_obj_expand (
        .plane_lo   (obj_lo),
        .plane_hi   (obj_hi),
        .mirror     (obj_flip),
        .slot_color (ob_color)
    );

    for (genvar j = 0; j < ROW_PIX; j++) begin : g_lane
        // slot addresses relative to each position, wrapped by width
        assign push_idx[j] = wr_ptr + AW'(j);
        assign obj_idx[j]  = rd_ptr + AW'(j);
        // object pixel lands only if opaque and slot not yet claimed
        assign lane_hit[j] = obj_valid && (ob_color[j] != 2'b00) && !mem[obj_idx[j]].obj;

        a_r8_keep_object: assert property (@(posedge clk) disable iff (!rst_n)
            (obj_valid && mem[obj_idx[j]].obj) |=> mem[$past(obj_idx[j])] == $past(mem[obj_idx[j]]));
    end

    // storage writes: row push or object overlay, never both
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) mem[s] <= '0;
        end else if (push_accept) begin
            for (int j = 0; j < ROW_PIX; j++)
                mem[push_idx[j]] <= '{obj: 1'b0, prio: push_prio, pal: push_pal, color: bg_color[j]};
        end else begin
            for (int j = 0; j < ROW_PIX; j++)
                if (lane_hit[j])
                    mem[obj_idx[j]] <= '{obj: 1'b1, prio: obj_prio, pal: obj_pal, color: ob_color[j]};
        end
    end

    // registered pop port with zero idle value on underflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q         <= '0;
            pix_valid     <= 1'b0;
            pix_underflow <= 1'b0;
        end else if (pop_req) begin
            out_q         <= not_empty ? mem[rd_ptr] : '0;
            pix_valid     <= not_empty;
            pix_underflow <= !not_empty;
        end else begin
            pix_valid     <= 1'b0;
            pix_underflow <= 1'b0;
        end
    end

    assign pix_color = out_q.color;
    assign pix_pal   = out_q.pal;
    assign pix_prio  = out_q.prio;
    assign pix_obj   = out_q.obj;

    a_r9_overlay_blocks_push: assert property (@(posedge clk) disable iff (!rst_n)
        obj_valid |-> !push_accept);

    a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && !obj_valid && level == '0) |=> (pix_underflow && !pix_valid));

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pix_underflow |-> (pix_color == 2'b00 && pix_pal == '0 && !pix_prio && !pix_obj));

    a_r11_pop_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_valid && !obj_valid && level != '0) |=> (pix_valid && level == $past(level) - LW'(1) + ($past(push_accept) ? LW'(ROW_PIX) : LW'(0))));
endmodule

// File: tb/test_pixel_shift_fifo.sv
module test_pixel_shift_fifo;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 16;
    localparam int LW     = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_valid = 0, push_prio = 0, push_flip = 0;
    logic [7:0] push_lo = 0, push_hi = 0;
    logic [2:0] push_pal = 0;
    logic obj_valid = 0, obj_prio = 0, obj_flip = 0;
    logic [7:0] obj_lo = 0, obj_hi = 0;
    logic [2:0] obj_pal = 0;
    logic pop_valid = 0;
    logic push_accept, pix_valid, pix_prio, pix_obj, pix_underflow;
    logic [1:0] pix_color;
    logic [2:0] pix_pal;
    logic [LW-1:0] level;

    int n_chk = 0;
    int n_bad = 0;

    // model: entry packed as {obj, prio, pal[2:0], color[1:0]}
    logic [6:0] m_mem [DEPTH];
    int m_rd, m_wr, m_cnt;

    always #(PERIOD/2) clk = ~clk;

    pixel_shift_fifo #(.DEPTH(DEPTH)) i_pixel_shift_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_lo(push_lo), .push_hi(push_hi),
        .push_pal(push_pal), .push_prio(push_prio), .push_flip(push_flip),
        .push_accept(push_accept),
        .obj_valid(obj_valid), .obj_lo(obj_lo), .obj_hi(obj_hi),
        .obj_pal(obj_pal), .obj_prio(obj_prio), .obj_flip(obj_flip),
        .pop_valid(pop_valid),
        .pix_valid(pix_valid), .pix_color(pix_color), .pix_pal(pix_pal),
        .pix_prio(pix_prio), .pix_obj(pix_obj), .pix_underflow(pix_underflow),
        .level(level)
    );

    function automatic logic [1:0] fpix(input logic [7:0] lo, input logic [7:0] hi,
                                        input logic flip, input int j);
        int b;
        b = flip ? j : 7 - j;
        return {hi[b], lo[b]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < DEPTH; s++) m_mem[s] = '0;
        m_rd = 0; m_wr = 0; m_cnt = 0;
    endtask

    task automatic clear_inputs();
        push_valid = 0; obj_valid = 0; pop_valid = 0;
    endtask

    // one cycle: inputs already set at a falling edge; check and advance model
    task automatic step(input string tag);
        logic exp_acc, pop_do, exp_v, exp_u;
        logic [6:0] exp_e;
        int idx;
        logic [1:0] c;
        #1;
        exp_acc = push_valid && !obj_valid && (DEPTH - m_cnt >= 8);
        chk(obj_valid ? "R9" : "R2", push_accept, exp_acc);
        pop_do = pop_valid && !obj_valid;
        exp_v = 0; exp_u = 0; exp_e = '0;
        if (pop_do) begin
            if (m_cnt > 0) begin exp_v = 1; exp_e = m_mem[m_rd]; end
            else exp_u = 1;
        end
        if (obj_valid) begin
            for (int j = 0; j < 8; j++) begin
                idx = (m_rd + j) % DEPTH;
                c = fpix(obj_lo, obj_hi, obj_flip, j);
                if (c != 2'b00 && !m_mem[idx][6]) m_mem[idx] = {1'b1, obj_prio, obj_pal, c};
            end
        end
        if (exp_acc) begin
            for (int j = 0; j < 8; j++)
                m_mem[(m_wr + j) % DEPTH] = {1'b0, push_prio, push_pal, fpix(push_lo, push_hi, push_flip, j)};
            m_wr = (m_wr + 8) % DEPTH;
            m_cnt += 8;
        end
        if (exp_v) begin
            m_rd = (m_rd + 1) % DEPTH;
            m_cnt -= 1;
        end
        @(posedge clk);
        @(negedge clk);
        chk("R2", 32'(level), 32'(m_cnt));
        chk(obj_valid ? "R9" : "R11", pix_valid, exp_v);
        chk(obj_valid ? "R9" : "R10", pix_underflow, exp_u);
        if (exp_v || exp_u)
            chk(tag, {pix_obj, pix_prio, pix_pal, pix_color}, exp_e);
        clear_inputs();
    endtask

    task automatic push_row(input logic [7:0] lo, input logic [7:0] hi, input logic [2:0] pal,
                            input logic prio, input logic flip, input string tag);
        push_valid = 1; push_lo = lo; push_hi = hi; push_pal = pal;
        push_prio = prio; push_flip = flip;
        step(tag);
    endtask

    task automatic overlay(input logic [7:0] lo, input logic [7:0] hi, input logic [2:0] pal,
                           input logic prio, input logic flip, input string tag);
        obj_valid = 1; obj_lo = lo; obj_hi = hi; obj_pal = pal;
        obj_prio = prio; obj_flip = flip;
        step(tag);
    endtask

    task automatic pop_n(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            pop_valid = 1;
            step(tag);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        clear_inputs();
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    initial begin
        #(PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20190105));
        model_reset();
        do_reset();
        // R1: state after reset
        chk("R1", 32'(level), 0);
        chk("R1", pix_valid, 0);
        chk("R1", pix_underflow, 0);
        // R10: pop on empty
        pop_n(1, "R10");

        // R3: plane bit weights
        push_row(8'hFF, 8'h00, 3'd2, 1'b0, 1'b0, "R3");
        pop_n(8, "R3");
        push_row(8'h00, 8'hFF, 3'd6, 1'b1, 1'b0, "R3");
        pop_n(8, "R3");
        // R4/R5: order without and with mirror, attributes carried
        push_row(8'hA6, 8'hC3, 3'd5, 1'b1, 1'b0, "R4");
        pop_n(8, "R4");
        push_row(8'hA6, 8'hC3, 3'd3, 1'b0, 1'b1, "R5");
        pop_n(8, "R5");

        // R2: fill to DEPTH, third row refused, then push with pop
        push_row(8'h12, 8'h34, 3'd1, 1'b0, 1'b0, "R2");
        push_row(8'h56, 8'h78, 3'd2, 1'b1, 1'b1, "R2");
        push_row(8'h9A, 8'hBC, 3'd3, 1'b0, 1'b0, "R2");
        pop_n(8, "R6");
        push_valid = 1; push_lo = 8'hDE; push_hi = 8'hF0; push_pal = 3'd4;
        push_prio = 1; push_flip = 0; pop_valid = 1;
        step("R6");
        pop_n(16, "R6");
        pop_n(1, "R10");

        // R7/R8: overlay onto a solid background row
        push_row(8'hFF, 8'hFF, 3'd1, 1'b0, 1'b0, "R7");
        overlay(8'h90, 8'h00, 3'd7, 1'b1, 1'b0, "R7");
        overlay(8'hFF, 8'hFF, 3'd2, 1'b0, 1'b0, "R8");
        pop_n(8, "R8");
        push_row(8'h00, 8'h00, 3'd0, 1'b0, 1'b0, "R7");
        overlay(8'h03, 8'h01, 3'd5, 1'b0, 1'b1, "R7");
        pop_n(8, "R7");

        // R9: overlay cycle blocks push and pop
        push_row(8'h0F, 8'hF0, 3'd3, 1'b0, 1'b0, "R9");
        push_valid = 1; pop_valid = 1; obj_valid = 1;
        obj_lo = 8'h00; obj_hi = 8'h00;
        step("R9");
        pop_n(8, "R9");

        // R1: reset mid-run empties the queue
        push_row(8'h55, 8'hAA, 3'd2, 1'b1, 1'b0, "R1");
        do_reset();
        chk("R1", 32'(level), 0);
        pop_n(1, "R1");

        // R6: random traffic across pointer wrap
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom % 10;
            if (r < 3) begin
                push_valid = 1; push_lo = 8'($urandom); push_hi = 8'($urandom);
                push_pal = 3'($urandom); push_prio = 1'($urandom); push_flip = 1'($urandom);
            end
            if (r >= 2 && r < 8) pop_valid = 1;
            if (r == 9) begin
                obj_valid = 1; obj_lo = 8'($urandom); obj_hi = 8'($urandom);
                obj_pal = 3'($urandom); obj_prio = 1'($urandom); obj_flip = 1'($urandom);
                push_valid = 1'($urandom); pop_valid = 1'($urandom);
            end
            step("R6");
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule